// File: doc/BRIEF.md
# Ethernet Pause Flow Control Unit

This block holds the flow control state of a MAC. It has a 32-bit control/status word that software reads and writes. The word carries a transmit-pause (Xoff) request latch and three read-only status flags. A countdown timer tracks the pause period that the link partner requests. Software, or a fetched receive descriptor that carries a pause flag, can set the Xoff request. A separate Xon write-one bit clears it. The level output `xoff_req_o` drives the pause-frame generator in the transmitter. It is high while the receive FIFO is over its threshold or while the latched request is set.

The MAC receive path reports each parsed pause command to the block. It gives the 16-bit quanta value and whether the command is an ordinary pause or a pause-low command. The timer loads that value and counts down one step per quantum tick. The paused flags clear when the timer reaches zero. `tx_hold_o` tells the transmitter that the timer is still running.

Top module: `pause_flow_ctl`

## Requirements
- R1: In `rd_data`, only bits 20 (paused-low), 19 (paused), 18 (full) and 17 (Xoff request) can be 1. Bit 16 (Xon) and every other bit always read 0.
- R2: A register write with bit 17 set makes bit 17 read 1 from the next cycle. It stays 1 until an Xon write.
- R3: A one-cycle pulse on `desc_pause_flag` sets the same latch as R2. Bit 17 reads 1 from the next cycle.
- R4: A register write with bit 16 set clears the latch in the next cycle. In the same cycle, it wins over a bit 17 write and over `desc_pause_flag`.
- R5: Writes to bits 20:18 and to every other bit except 17 and 16 have no effect on the state.
- R6: `xoff_req_o` and bit 18 both equal `fifo_thresh_hit` OR the latched request, in the same cycle.
- R7: A received pause with `rx_pause_low`=0 and nonzero quanta does three things from the next cycle. It loads the timer with the quanta, sets paused (bit 19) and clears paused-low (bit 20).
- R8: A received pause with `rx_pause_low`=1 and nonzero quanta does two things from the next cycle. It loads the timer and sets paused-low (bit 20). Bit 19 is left unchanged.
- R9: A received pause with zero quanta clears the timer and both paused flags in the next cycle.
- R10: Each `quantum_tick` cycle without a received pause decrements a nonzero timer by one. When the timer reaches zero, both paused flags clear. A tick while the timer is zero has no effect. A received pause in the same cycle as a tick takes priority over the tick.
- R11: `tx_hold_o` is 1 exactly while the timer is nonzero. After a load of N, it falls after the Nth later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Write data; bit 17 sets Xoff, bit 16 is Xon |
| reg_rd_data | output | 32 | Current control/status word |
| fifo_thresh_hit | input | 1 | Receive FIFO is at or above its flow control threshold |
| desc_pause_flag | input | 1 | Pulse: a fetched receive descriptor carries a pause flag |
| rx_pause_valid | input | 1 | Pulse: a pause command was received |
| rx_pause_low | input | 1 | The received command is a pause-low command |
| rx_pause_quanta | input | 16 | Pause value of the received command |
| quantum_tick | input | 1 | One pause quantum has elapsed |
| xoff_req_o | output | 1 | Level request to send a pause frame |
| tx_hold_o | output | 1 | Pause timer is running |

## Verification
The assertions assume that every input is synchronous to `clk` and known whenever reset is released. They treat `rx_pause_quanta` and `rx_pause_low` as meaningful only in a cycle where `rx_pause_valid` is high. They also assume that ticks and pause commands may coincide in any cycle. The stimulus changes inputs only on the falling edge, and it draws quanta from small values so that the timer expires many times. It also mixes random write data, which covers every bit pattern, with directed coincidences of Xon, Xoff and descriptor pulses and with back-to-back pause commands.

// File: rtl/pause_flow_ctl.sv
module pause_flow_ctl #(
  parameter int WORD_W   = 32,
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [WORD_W-1:0]   reg_wr_data,
  output logic [WORD_W-1:0]   reg_rd_data,
  input  logic                fifo_thresh_hit,
  input  logic                desc_pause_flag,
  input  logic                rx_pause_valid,
  input  logic                rx_pause_low,
  input  logic [QUANTA_W-1:0] rx_pause_quanta,
  input  logic                quantum_tick,
  output logic                xoff_req_o,
  output logic                tx_hold_o
);
  localparam int BIT_XON   = 16;
  localparam int BIT_XOFF  = 17;
  localparam int BIT_FULL  = 18;
  localparam int BIT_PSD   = 19;
  localparam int BIT_PSDLO = 20;

  logic                xoff_latch;
  logic                paused, paused_low;
  logic [QUANTA_W-1:0] timer;

  wire xon_wr  = reg_wr_en & reg_wr_data[BIT_XON];
  wire xoff_wr = reg_wr_en & reg_wr_data[BIT_XOFF];
  wire nz_cmd  = rx_pause_valid & (rx_pause_quanta != '0);
  wire expire  = quantum_tick & (timer == QUANTA_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            xoff_latch <= 1'b0;
    else if (xon_wr)       xoff_latch <= 1'b0;
    else if (xoff_wr || desc_pause_flag) xoff_latch <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      timer      <= '0;
      paused     <= 1'b0;
      paused_low <= 1'b0;
    end else if (rx_pause_valid) begin
      timer <= rx_pause_quanta;
      if (!nz_cmd) begin
        paused     <= 1'b0;
        paused_low <= 1'b0;
      end else if (rx_pause_low) begin
        paused_low <= 1'b1;
      end else begin
        paused     <= 1'b1;
        paused_low <= 1'b0;
      end
    end else if (quantum_tick && timer != '0) begin
      timer <= timer - 1'b1;
      if (expire) begin
        paused     <= 1'b0;
        paused_low <= 1'b0;
      end
    end

  assign xoff_req_o = fifo_thresh_hit | xoff_latch;
  assign tx_hold_o  = timer != '0;

  always_comb begin
    reg_rd_data            = '0;
    reg_rd_data[BIT_XOFF]  = xoff_latch;
    reg_rd_data[BIT_FULL]  = xoff_req_o;
    reg_rd_data[BIT_PSD]   = paused;
    reg_rd_data[BIT_PSDLO] = paused_low;
  end

  p_xoff_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_wr && !xon_wr) |=> reg_rd_data[BIT_XOFF]);
  p_desc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_pause_flag && !xon_wr) |=> reg_rd_data[BIT_XOFF]);
  p_xon_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xon_wr |=> !xoff_req_o || fifo_thresh_hit);
  p_paused_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_cmd && !rx_pause_low) |=> (paused && !paused_low && tx_hold_o));
  p_low_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_cmd && rx_pause_low) |=> (paused_low && $stable(paused)));
  p_zero_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_valid && !nz_cmd) |=> !(paused || paused_low || tx_hold_o));
  p_tick_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (quantum_tick && !rx_pause_valid && tx_hold_o) |=> timer == $past(timer) - 1'b1);
  p_flags_need_timer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (paused || paused_low) |-> tx_hold_o);
endmodule

// File: tb/pause_flow_ctl_tb.sv
module pause_flow_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, fifo_thresh_hit = 0, desc_pause_flag = 0;
  logic rx_pause_valid = 0, rx_pause_low = 0, quantum_tick = 0;
  logic [31:0] reg_wr_data = 0, reg_rd_data;
  logic [15:0] rx_pause_quanta = 0;
  logic xoff_req_o, tx_hold_o;
  int checks = 0, fails = 0;
  bit m_latch = 0, m_psd = 0, m_low = 0;
  int m_timer = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_flow_ctl dut_i (.*);

  initial begin
    #(CLK_PERIOD*150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[20] = m_low; w[19] = m_psd; w[18] = fifo_thresh_hit | m_latch; w[17] = m_latch;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_update();
    bit xon  = reg_wr_en & reg_wr_data[16];
    bit xoff = reg_wr_en & reg_wr_data[17];
    if (xon) m_latch = 0; else if (xoff || desc_pause_flag) m_latch = 1;
    if (rx_pause_valid) begin
      m_timer = rx_pause_quanta;
      if (rx_pause_quanta == 0) begin m_psd = 0; m_low = 0; end
      else if (rx_pause_low) m_low = 1;
      else begin m_psd = 1; m_low = 0; end
    end else if (quantum_tick && m_timer != 0) begin
      m_timer--;
      if (m_timer == 0) begin m_psd = 0; m_low = 0; end
    end
  endtask

  task automatic step_cmp();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R2/R4 xoff bit", {31'b0, reg_rd_data[17]}, {31'b0, m_latch});
    chk("R7 paused bit", {31'b0, reg_rd_data[19]}, {31'b0, m_psd});
    chk("R8 paused-low bit", {31'b0, reg_rd_data[20]}, {31'b0, m_low});
    chk("R6 full bit and xoff_req_o", {30'b0, reg_rd_data[18], xoff_req_o},
        {30'b0, fifo_thresh_hit | m_latch, fifo_thresh_hit | m_latch});
    chk("R1/R5 word", reg_rd_data, exp_word());
    chk("R10/R11 tx_hold_o", {31'b0, tx_hold_o}, {31'b0, m_timer != 0});
  endtask

  task automatic idle();
    reg_wr_en = 0; reg_wr_data = 0; desc_pause_flag = 0;
    rx_pause_valid = 0; rx_pause_low = 0; rx_pause_quanta = 0; quantum_tick = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset word", reg_rd_data, 32'h0);
    chk("R11 reset tx_hold_o", {31'b0, tx_hold_o}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R2: software Xoff, then R5: write with only status/reserved bits
    idle(); reg_wr_en = 1; reg_wr_data = 32'h0002_0000; step_cmp();
    chk("R2 xoff read", {31'b0, reg_rd_data[17]}, 32'h1);
    idle(); reg_wr_en = 1; reg_wr_data = 32'hFFFC_FFFF; step_cmp();
    chk("R5 ignored bits", reg_rd_data, 32'h0006_0000);
    // R4: Xon and Xoff together -> clear; Xon reads 0 (R1)
    idle(); reg_wr_en = 1; reg_wr_data = 32'h0003_0000; desc_pause_flag = 1; step_cmp();
    chk("R4 xon priority", reg_rd_data, 32'h0);
    // R3: descriptor flag
    idle(); desc_pause_flag = 1; step_cmp();
    idle(); step_cmp();
    chk("R3 desc latch held", reg_rd_data, 32'h0006_0000);
    idle(); reg_wr_en = 1; reg_wr_data = 32'h0001_0000; step_cmp();
    // R6: threshold alone
    idle(); fifo_thresh_hit = 1; step_cmp();
    chk("R6 threshold only", {reg_rd_data[31:1], xoff_req_o}, {32'h0004_0000 >> 1, 1'b1});
    fifo_thresh_hit = 0;
    // R7/R8/R11: pause 3 then low, ticks
    idle(); rx_pause_valid = 1; rx_pause_quanta = 3; step_cmp();
    chk("R7 paused set", reg_rd_data, 32'h0008_0000);
    idle(); rx_pause_valid = 1; rx_pause_low = 1; rx_pause_quanta = 2; step_cmp();
    chk("R8 low set keeps paused", reg_rd_data, 32'h0018_0000);
    idle(); quantum_tick = 1; step_cmp();
    chk("R11 hold after 1 tick", {31'b0, tx_hold_o}, 32'h1);
    step_cmp();
    chk("R10 flags clear at zero", reg_rd_data, 32'h0);
    chk("R11 hold fell", {31'b0, tx_hold_o}, 32'h0);
    step_cmp();
    // R7 clears low; R9 zero quanta
    idle(); rx_pause_valid = 1; rx_pause_low = 1; rx_pause_quanta = 9; step_cmp();
    idle(); rx_pause_valid = 1; rx_pause_quanta = 9; quantum_tick = 1; step_cmp();
    chk("R7 pause clears low", reg_rd_data, 32'h0008_0000);
    idle(); rx_pause_valid = 1; rx_pause_quanta = 0; step_cmp();
    chk("R9 zero clears", {reg_rd_data[31:1], tx_hold_o}, 32'h0);

    // random
    for (int i = 0; i < 4000; i++) begin
      idle();
      reg_wr_en       = ($urandom % 6) == 0;
      reg_wr_data     = $urandom;
      desc_pause_flag = ($urandom % 10) == 0;
      fifo_thresh_hit = ($urandom % 4) == 0;
      rx_pause_valid  = ($urandom % 12) == 0;
      rx_pause_low    = $urandom % 2;
      rx_pause_quanta = ($urandom % 5 == 0) ? 16'($urandom) : 16'($urandom % 8);
      quantum_tick    = $urandom % 2;
      step_cmp();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule